// File: doc/BRIEF.md
# Paged Serial EEPROM Target on a Two-Wire Bus

This block answers on a two-wire serial bus as a byte-addressed non-volatile memory, with a register array behind it. A host opens a transfer with a start condition and sends a control byte. That byte carries a fixed device-type code, some upper address bits and a read/write flag. For a write, the host then sends one or two address bytes, chosen by a parameter, followed by data bytes. The data bytes gather in a page buffer, and the array is updated only when a stop condition arrives. After that stop the block models the internal programming time of a real part: for a parameterised number of system clocks it acknowledges nothing.

An internal address pointer serves three kinds of read:
- A current-address read, which is a read control byte sent straight after a start.
- A random read, which is a write carrying only the address, then a repeated start, then a read control byte.
- A sequential read, where the host acknowledges each byte to receive the next one.

Both bus lines are first brought into the system clock domain and filtered. Start, stop and clock edges are recognised only after that. The block drives the data line only through an open-drain enable.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A control byte is acknowledged only when its bits 7:4 are 1010 (bit 0 = 1 for read, 0 for write). The acknowledge is the data line held low through the ninth clock. Any other control byte gets no acknowledge, and every byte after it is ignored until the next start.
- R2: With ADDR_BYTES = 1, the address is {control bits 3:1, address byte}, cut to the memory's address width. With ADDR_BYTES = 2, the high address byte comes first and control bits 3:1 are not used for the address. Each accepted address byte is acknowledged.
- R3: Each data byte of a write goes to the current pointer. The pointer then advances only within its aligned page of PAGE_BYTES, so a write that runs past the page end continues at the start of that page.
- R4: A write with more data bytes than PAGE_BYTES overwrites the bytes placed earlier in the same transfer. For each location, the last byte sent there is the one stored.
- R5: Buffered data reaches the array only on a stop. A start that arrives before the stop discards the buffered bytes, and in that case no write cycle begins.
- R6: A stop that commits at least one byte starts a write cycle of WRITE_CYCLES system clocks. During that cycle, no control byte is acknowledged.
- R7: The pointer holds the location after the last byte read or written. During reads it wraps from the last memory location to address 0.
- R8: A read control byte returns the byte at the pointer. Each acknowledge from the host (data low on the ninth clock) causes the next byte to be sent. A high ninth bit ends the read.
- R9: After reset, the data line is released, every memory byte is 0x00 and the pointer is 0.
- R10: A level on either line that lasts fewer than FILT_LEN system clocks after synchronisation is ignored. Such a glitch on the data line while the clock is high causes neither a start nor a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
Each line passes through a two-flop synchroniser, a FILT_LEN-sample filter, an edge register and the output register. As a result, an acknowledge or read data bit appears on `sda_oe` about eight system clocks after the bus clock falls. The bench therefore keeps at least sixteen clocks between a bus clock fall and the next rise. It samples the data line in the middle of the high phase, on the falling system clock edge. The write cycle begins on the stop. The bench polls once right after the stop to observe the silent period, then waits WRITE_CYCLES plus a margin before the next access. Every stored value is read back over the bus and compared with a byte model that applies the page wrap arithmetically.

// File: rtl/eei_pkg.sv
// Shared types for the serial EEPROM target.
// Assumes nothing beyond the two-wire framing: 8 data bits, then one acknowledge bit.
package eei_pkg;

    // Bus-level phase of the target.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        RX_CTRL,
        RX_AHI,
        RX_ALO,
        RX_DATA
    } rx_role_e;

    // Device-type code expected in bits 7:4 of the control byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eei_line_filter.sv
// Synchronises one bus line into clk and removes short pulses.
// The output moves only after FILT_LEN consecutive equal samples.
// Assumes FILT_LEN >= 2. Resets to the idle-high bus level.
module eei_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Two-flop synchroniser, a sample history, and a filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q) begin
                clean <= 1'b1;
            end else if (~|hist_q) begin
                clean <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/eei_store.sv
// Memory array, page buffer and write-cycle timer.
// Written bytes collect in the buffer. A commit request copies the valid
// bytes into the addressed page in one clock and loads the busy timer.
// A drop empties the buffer without writing anything.
// Assumes MEM_BYTES and PAGE_BYTES are powers of two, with 2 <= PAGE_BYTES < MEM_BYTES.
module eei_store #(
    parameter int MEM_BYTES    = 128,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 500,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int TW = $clog2(WRITE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          drop,
    input  logic          commit_req,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          commit
);

    logic [7:0]         mem_q  [MEM_BYTES];
    logic [7:0]         pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid_q;
    logic [AW-PW-1:0]   page_q;
    logic [TW-1:0]      timer_q;

    assign commit  = commit_req && (|pvalid_q);
    assign busy    = (timer_q != '0);
    assign rd_data = mem_q[rd_addr];

    // Page buffer: fill on each write, empty on drop or commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid_q <= '0;
            page_q   <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= 8'h00;
        end else if (drop || commit) begin
            pvalid_q <= '0;
        end else if (wr_en) begin
            pbuf_q[wr_addr[PW-1:0]]   <= wr_data;
            pvalid_q[wr_addr[PW-1:0]] <= 1'b1;
            page_q                    <= wr_addr[AW-1:PW];
        end
    end

    // Array: clear on reset, take the buffered bytes on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvalid_q[i]) mem_q[{page_q, PW'(i)}] <= pbuf_q[i];
            end
        end
    end

    // Write-cycle timer: load on commit, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (commit) begin
            timer_q <= TW'(WRITE_CYCLES);
        end else if (timer_q != '0) begin
            timer_q <= timer_q - 1'b1;
        end
    end

endmodule

// File: rtl/eei_proto.sv
// Bus protocol engine. Receives the filtered lines, detects start, stop and
// clock edges, and steps through the control, address, data and acknowledge
// phases. It owns the address pointer.
// Assumes the filtered clock and data never change in the same clock.
module eei_proto
    import eei_pkg::*;
#(
    parameter int AW         = 7,
    parameter int PW         = 3,
    parameter int ADDR_BYTES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic          busy,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          drop,
    output logic          commit_req,
    output logic          ctrl_ack,
    output logic [AW-1:0] ptr
);

    logic       scl_q, sda_q;
    logic       rise, fall, start_ev, stop_ev;
    bus_state_e state_q;
    rx_role_e   role_q;
    logic [2:0] cnt_q;
    logic [7:0] sr_q;
    logic [6:0] tx_q;
    logic [7:0] ahi_q;
    logic [2:0] cbits_q;
    logic       go_tx_q, done_q, mack_q;
    logic [AW-1:0] full_addr;

    assign rise     = scl && !scl_q;
    assign fall     = !scl && scl_q;
    assign start_ev = scl && scl_q && sda_q && !sda;
    assign stop_ev  = scl && scl_q && !sda_q && sda;

    // Build the full address from the stored high part and the low byte.
    always_comb begin
        if (ADDR_BYTES == 2) full_addr = AW'({ahi_q, sr_q});
        else                 full_addr = AW'({cbits_q, sr_q});
    end

    // Keep the previous line levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            role_q     <= RX_CTRL;
            cnt_q      <= '0;
            sr_q       <= '0;
            tx_q       <= '0;
            ahi_q      <= '0;
            cbits_q    <= '0;
            go_tx_q    <= 1'b0;
            done_q     <= 1'b0;
            mack_q     <= 1'b0;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            drop       <= 1'b0;
            commit_req <= 1'b0;
            ctrl_ack   <= 1'b0;
            ptr        <= '0;
        end else begin
            wr_en      <= 1'b0;
            drop       <= 1'b0;
            commit_req <= 1'b0;
            ctrl_ack   <= 1'b0;
            if (start_ev) begin
                state_q <= ST_RX;
                role_q  <= RX_CTRL;
                cnt_q   <= '0;
                done_q  <= 1'b0;
                sda_oe  <= 1'b0;
                drop    <= 1'b1;
            end else if (stop_ev) begin
                state_q    <= ST_IDLE;
                sda_oe     <= 1'b0;
                commit_req <= 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                    end
                    ST_RX: begin
                        if (rise) begin
                            sr_q  <= {sr_q[6:0], sda};
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == 3'd7) done_q <= 1'b1;
                        end else if (fall && done_q) begin
                            done_q <= 1'b0;
                            cnt_q  <= '0;
                            unique case (role_q)
                                RX_CTRL: begin
                                    if (sr_q[7:4] == DEV_TYPE && !busy) begin
                                        sda_oe   <= 1'b1;
                                        ctrl_ack <= 1'b1;
                                        cbits_q  <= sr_q[3:1];
                                        go_tx_q  <= sr_q[0];
                                        state_q  <= ST_RX_ACK;
                                        role_q   <= (ADDR_BYTES == 2) ? RX_AHI : RX_ALO;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                RX_AHI: begin
                                    ahi_q   <= sr_q;
                                    role_q  <= RX_ALO;
                                    sda_oe  <= 1'b1;
                                    state_q <= ST_RX_ACK;
                                end
                                RX_ALO: begin
                                    ptr     <= full_addr;
                                    role_q  <= RX_DATA;
                                    sda_oe  <= 1'b1;
                                    state_q <= ST_RX_ACK;
                                end
                                RX_DATA: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= sr_q;
                                    ptr     <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                                    sda_oe  <= 1'b1;
                                    state_q <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (fall) begin
                            go_tx_q <= 1'b0;
                            if (go_tx_q) begin
                                tx_q    <= rd_data[6:0];
                                sda_oe  <= ~rd_data[7];
                                cnt_q   <= '0;
                                state_q <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (fall) begin
                            if (cnt_q == 3'd7) begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_TX_ACK;
                            end else begin
                                sda_oe <= ~tx_q[6];
                                tx_q   <= {tx_q[5:0], 1'b0};
                                cnt_q  <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (rise) begin
                            mack_q <= !sda;
                            ptr    <= ptr + 1'b1;
                        end else if (fall) begin
                            if (mack_q) begin
                                tx_q    <= rd_data[6:0];
                                sda_oe  <= ~rd_data[7];
                                cnt_q   <= '0;
                                state_q <= ST_TX;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_target.sv
// Top of the serial EEPROM target: line filters, protocol engine and storage.
// Assumes the pad ties the data line low whenever sda_oe is 1, and that
// the system clock is many times faster than the bus clock.
module eeprom_i2c_target #(
    parameter int MEM_BYTES    = 128,
    parameter int PAGE_BYTES   = 8,
    parameter int ADDR_BYTES   = 1,
    parameter int WRITE_CYCLES = 500,
    parameter int FILT_LEN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [1:0]    raw_lines, clean_lines;
    logic          scl_f, sda_f;
    logic          busy, commit, ctrl_ack;
    logic          wr_en, drop, commit_req;
    logic [AW-1:0] wr_addr, ptr;
    logic [7:0]    wr_data, rd_data;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = clean_lines[0];
    assign sda_f     = clean_lines[1];

    for (genvar g = 0; g < 2; g++) begin : g_line
        eei_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    eei_proto #(.AW(AW), .PW(PW), .ADDR_BYTES(ADDR_BYTES)) i_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl_f),
        .sda        (sda_f),
        .busy       (busy),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .drop       (drop),
        .commit_req (commit_req),
        .ctrl_ack   (ctrl_ack),
        .ptr        (ptr)
    );

    eei_store #(
        .MEM_BYTES    (MEM_BYTES),
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .drop       (drop),
        .commit_req (commit_req),
        .rd_addr    (ptr),
        .rd_data    (rd_data),
        .busy       (busy),
        .commit     (commit)
    );

endmodule

// File: rtl/eei_checker.sv
// Temporal checks on the EEPROM target, bound into every instance of the top.
// Assumes the same reset as the design.
module eei_checker #(
    parameter int AW           = 7,
    parameter int PW           = 3,
    parameter int WRITE_CYCLES = 500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             busy,
    input logic             commit,
    input logic             ctrl_ack,
    input logic             wr_en,
    input logic [AW-PW-1:0] wr_page,
    input logic [AW-PW-1:0] ptr_page
);

    int unsigned busy_run;

    // Length of the current busy stretch, for the window check.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_ack_starts_low_scl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    assert_write_stays_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr_page == wr_page));

    assert_commit_starts_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    assert_silent_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ctrl_ack));

    assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WRITE_CYCLES);

endmodule

bind eeprom_i2c_target eei_checker #(
    .AW           (AW),
    .PW           (PW),
    .WRITE_CYCLES (WRITE_CYCLES)
) i_eei_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .commit   (commit),
    .ctrl_ack (ctrl_ack),
    .wr_en    (wr_en),
    .wr_page  (wr_addr[AW-1:PW]),
    .ptr_page (ptr[AW-1:PW])
);

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;

    localparam int MEM = 128;
    localparam int PG  = 8;
    localparam int WC  = 1200;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    logic [7:0] model [MEM];
    logic [7:0] wbuf [16];
    int         bptr = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_i2c_target #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PG), .ADDR_BYTES(1),
        .WRITE_CYCLES(WC), .FILT_LEN(3)
    ) i_eeprom_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1;
            if (glitch && i == 7) begin
                tick(Q / 2); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(2 * Q - Q / 2 - 2);
            end else begin
                tick(2 * Q);
            end
            scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2 * Q); scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl = 1'b0;
        end
        tick(Q); sda_m = ~mack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    // Write n bytes from wbuf starting at addr; the model wraps inside the page.
    task automatic do_write(int addr, int n, bit glitch);
        bit a;
        bus_start();
        send_byte(8'hA0, 1'b0, a); check("R1 write control ack", a, 1'b1);
        send_byte(addr[7:0], 1'b0, a); check("R2 address ack", a, 1'b1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], glitch && k == 0, a);
            check("R3 data ack", a, 1'b1);
            model[(addr / PG) * PG + ((addr + k) % PG)] = wbuf[k];
        end
        bptr = (addr / PG) * PG + ((addr + n) % PG);
        bus_stop();
    endtask

    task automatic cur_read(int n, string req);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA1, 1'b0, a); check({req, " read control ack"}, a, 1'b1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(req, b, model[bptr]);
            bptr = (bptr + 1) % MEM;
        end
        bus_stop();
    endtask

    task automatic rnd_read(int addr, int n, string req);
        bit a;
        bus_start();
        send_byte(8'hA0, 1'b0, a); check("R1 dummy write ack", a, 1'b1);
        send_byte(addr[7:0], 1'b0, a); check("R2 address ack", a, 1'b1);
        bptr = addr;
        cur_read(n, req);
    endtask

    task automatic poll(bit expect_ack, string req);
        bit a;
        bus_start();
        send_byte(8'hA0, 1'b0, a);
        check(req, a, expect_ack);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        check("R9 data line released after reset", sda_oe, 1'b0);
        cur_read(1, "R9 pointer and memory zero after reset");

        // Fill the whole array page by page; the first commit also checks the silent period.
        for (int p = 0; p < MEM / PG; p++) begin
            for (int k = 0; k < PG; k++) wbuf[k] = 8'((p * PG + k) * 7 + 3);
            do_write(p * PG, PG, 1'b0);
            if (p == 0) poll(1'b0, "R6 no ack during write cycle");
            tick(WC + 50);
            if (p == 0) poll(1'b1, "R6 ack after write cycle");
        end
        rnd_read(0, MEM, "R2 full array sequential readback");

        // A control byte of another type is ignored with the bytes after it.
        bus_start();
        send_byte(8'hB0, 1'b0, a); check("R1 foreign type no ack", a, 1'b0);
        send_byte(8'h10, 1'b0, a); check("R1 bytes ignored after foreign type", a, 1'b0);
        send_byte(8'hEE, 1'b0, a); check("R1 data ignored after foreign type", a, 1'b0);
        bus_stop();
        rnd_read(8'h10, 1, "R1 location untouched");

        // Write past the page end wraps to the page start.
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
        do_write(8'h1E, 4, 1'b0);
        tick(WC + 50);
        rnd_read(8'h18, 8, "R3 page wrap");

        // More bytes than the page holds overwrite the earliest ones.
        for (int k = 0; k < 10; k++) wbuf[k] = 8'h50 + 8'(k);
        do_write(8'h20, 10, 1'b0);
        tick(WC + 50);
        rnd_read(8'h20, 8, "R4 page overrun");

        // Sequential read across the end of memory, then a current-address read.
        rnd_read(8'h7E, 3, "R7 read wraps to zero");
        cur_read(1, "R8 current address read");

        // A repeated start before the stop discards the buffered byte.
        bus_start();
        send_byte(8'hA0, 1'b0, a); check("R5 control ack", a, 1'b1);
        send_byte(8'h40, 1'b0, a); check("R5 address ack", a, 1'b1);
        send_byte(8'h5A, 1'b0, a); check("R5 data ack", a, 1'b1);
        bus_start();
        send_byte(8'hA1, 1'b0, a); check("R5 no write cycle after discard", a, 1'b1);
        recv_byte(1'b0, b); check("R7 pointer after written byte", b, model[8'h41]);
        bus_stop();
        rnd_read(8'h40, 1, "R5 discarded byte not stored");

        // Pointer follows the last written byte.
        wbuf[0] = 8'h3C;
        do_write(8'h50, 1, 1'b0);
        tick(WC + 50);
        cur_read(1, "R7 pointer after write");

        // A short data-line glitch while the clock is high is not a condition.
        wbuf[0] = 8'h9C;
        do_write(8'h60, 1, 1'b1);
        tick(WC + 50);
        rnd_read(8'h60, 1, "R10 glitch filtered");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule